// File: doc/BRIEF.md
# Slot-Counting Pulse-Width Modulator

This block turns a stream of unsigned sample words into a single serial line whose high time, counted in whole clock slots, equals the value of the sample. Time is divided into frames of fixed length. Each frame holds `2^SAMPLE_W` data slots followed by `GUARD_SLOTS` guard slots, during which the line is always low. The guard slots keep the pulse of one frame from running into the pulse of the next. The slot clock therefore runs at the frame rate times `2^SAMPLE_W + GUARD_SLOTS`.

A converter upstream offers words with a one-cycle valid strobe, at any point in a frame. A word that arrives is held in a pending register. At the frame boundary the pending word moves into a compare register that stays fixed for the whole frame. A slot counter restarts at zero on every frame. The line is raised at slot 0 when the held word is non-zero, and it drops on the slot where the counter equals the held word. A one-cycle frame-start flag marks slot 0 of every frame. Everything runs on the slot clock.

Top module: `dpwm_modulator`

## Requirements
- R1: `frame_start_o` is high for exactly one cycle in every `2^SAMPLE_W + GUARD_SLOTS` cycles (18 with defaults), and low on all the other slots of the frame.
- R2: While `rst_ni` is low, `pwm_o` is 0 and `frame_start_o` is 1. The first cycle after release is slot 0 of a frame. Reset clears both the pending word and the held word, so the first frame after reset is low throughout.
- R3: For a held word v with 0 < v < 2^SAMPLE_W, `pwm_o` is 1 on slots 0..v-1 of the frame and 0 from slot v onward. The pulse ends on the slot where the counter equals v.
- R4: A held word of 0 keeps `pwm_o` low for the whole frame.
- R5: On the guard slots, which are slots `2^SAMPLE_W` to `2^SAMPLE_W + GUARD_SLOTS - 1`, `pwm_o` is 0 for every sample value, including the maximum `2^SAMPLE_W - 1`.
- R6: A word accepted while a frame is running does not change the pulse of that frame. It sets the width of the next frame.
- R7: When more than one word is accepted in one frame, the last one sets the width of the next frame.
- R8: When no word is accepted in a frame, the next frame repeats the width of the previous one.
- R9: With `BYPASS_EDGE = 1` (the default), a word accepted in the last slot of a frame sets the width of the frame that starts on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slot clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| smp_valid_i | input | 1 | One-cycle strobe: `smp_data_i` carries a new word |
| smp_data_i | input | SAMPLE_W | Unsigned sample word |
| pwm_o | output | 1 | Registered pulse-width-modulated line |
| frame_start_o | output | 1 | Registered flag, high on slot 0 of each frame |

## Verification
The checker keeps its own slot count, which starts when reset is released. Its frame-period and guard properties therefore assume that reset is synchronous, lasts at least one clock edge, and is never released between edges. The rising-edge and zero-width properties take no input into account, because they hold for any strobe pattern. The bench changes the strobe and data only on falling edges, one word per strobe, with values inside `SAMPLE_W` bits. It places strobes at the first, a middle, the next-to-last and the last slot of a frame, so the pending path and the boundary bypass are each exercised on their own.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
   // slots in one frame: data slots plus guard slots
   function automatic int unsigned frame_slots(int unsigned sample_w, int unsigned guard);
      return (32'd1 << sample_w) + guard;
   endfunction
endpackage

// File: rtl/dpwm_slot_counter.sv
module dpwm_slot_counter #(
   parameter int unsigned SAMPLE_W    = 4,
   parameter int unsigned GUARD_SLOTS = 2,
   localparam int unsigned FRAME      = dpwm_pkg::frame_slots(SAMPLE_W, GUARD_SLOTS),
   localparam int unsigned CW         = $clog2(FRAME)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   output logic [CW-1:0] cnt_nxt_o,
   output logic          wrap_nxt_o
);
   localparam logic [CW-1:0] LAST = CW'(FRAME - 1);

   logic [CW-1:0] cnt_q;

   always_comb begin
      if (!rst_ni)            cnt_nxt_o = '0;
      else if (cnt_q == LAST) cnt_nxt_o = '0;
      else                    cnt_nxt_o = cnt_q + 1'b1;
   end

   assign wrap_nxt_o = (cnt_nxt_o == '0);

   always_ff @(posedge clk_i) begin
      cnt_q <= cnt_nxt_o;
   end
endmodule

// File: rtl/dpwm_sample_hold.sv
module dpwm_sample_hold #(
   parameter int unsigned SAMPLE_W    = 4,
   parameter bit          BYPASS_EDGE = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                load_i,
   input  logic                smp_valid_i,
   input  logic [SAMPLE_W-1:0] smp_data_i,
   output logic [SAMPLE_W-1:0] hold_nxt_o
);
   logic [SAMPLE_W-1:0] pend_q;
   logic [SAMPLE_W-1:0] hold_q;
   logic [SAMPLE_W-1:0] load_val;

   generate
      if (BYPASS_EDGE) begin : g_bypass
         // a word arriving on the boundary slot goes straight to the compare register
         assign load_val = smp_valid_i ? smp_data_i : pend_q;
      end else begin : g_pending_only
         assign load_val = pend_q;
      end
   endgenerate

   always_comb begin
      if (!rst_ni)     hold_nxt_o = '0;
      else if (load_i) hold_nxt_o = load_val;
      else             hold_nxt_o = hold_q;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pend_q <= '0;
      end else if (smp_valid_i) begin
         pend_q <= smp_data_i;
      end
      hold_q <= hold_nxt_o;
   end
endmodule

// File: rtl/dpwm_edge_gen.sv
module dpwm_edge_gen #(
   parameter int unsigned SAMPLE_W = 4,
   parameter int unsigned CW       = 5
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [CW-1:0]       cnt_nxt_i,
   input  logic                wrap_nxt_i,
   input  logic [SAMPLE_W-1:0] hold_nxt_i,
   output logic                pwm_o,
   output logic                frame_start_o
);
   localparam logic [CW-1:0] DATA_END = CW'(32'd1 << SAMPLE_W);

   logic [CW-1:0] hold_ext;
   logic          pwm_nxt;

   assign hold_ext = {{(CW - SAMPLE_W){1'b0}}, hold_nxt_i};

   always_comb begin
      if (wrap_nxt_i) begin
         pwm_nxt = (hold_nxt_i != '0);
      end else begin
         // equality with the held word ends the pulse; guard slots force low
         pwm_nxt = pwm_o && (cnt_nxt_i != hold_ext) && (cnt_nxt_i < DATA_END);
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pwm_o         <= 1'b0;
         frame_start_o <= 1'b1;
      end else begin
         pwm_o         <= pwm_nxt;
         frame_start_o <= wrap_nxt_i;
      end
   end
endmodule

// File: rtl/dpwm_modulator.sv
module dpwm_modulator #(
   parameter int unsigned SAMPLE_W    = 4,
   parameter int unsigned GUARD_SLOTS = 2,
   parameter bit          BYPASS_EDGE = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                smp_valid_i,
   input  logic [SAMPLE_W-1:0] smp_data_i,
   output logic                pwm_o,
   output logic                frame_start_o
);
   localparam int unsigned FRAME = dpwm_pkg::frame_slots(SAMPLE_W, GUARD_SLOTS);
   localparam int unsigned CW    = $clog2(FRAME);

   generate
      if (SAMPLE_W < 1 || SAMPLE_W > 16) begin : g_bad_width
         $error("dpwm_modulator: SAMPLE_W must lie in 1..16");
      end
      if (GUARD_SLOTS < 1) begin : g_bad_guard
         $error("dpwm_modulator: GUARD_SLOTS must be at least 1");
      end
   endgenerate

   logic [CW-1:0]       cnt_nxt;
   logic                wrap_nxt;
   logic [SAMPLE_W-1:0] hold_nxt;

   dpwm_slot_counter #(
      .SAMPLE_W   (SAMPLE_W),
      .GUARD_SLOTS(GUARD_SLOTS)
   ) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cnt_nxt_o (cnt_nxt),
      .wrap_nxt_o(wrap_nxt)
   );

   dpwm_sample_hold #(
      .SAMPLE_W   (SAMPLE_W),
      .BYPASS_EDGE(BYPASS_EDGE)
   ) u_hold (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (wrap_nxt),
      .smp_valid_i(smp_valid_i),
      .smp_data_i (smp_data_i),
      .hold_nxt_o (hold_nxt)
   );

   dpwm_edge_gen #(
      .SAMPLE_W(SAMPLE_W),
      .CW      (CW)
   ) u_edge (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .cnt_nxt_i    (cnt_nxt),
      .wrap_nxt_i   (wrap_nxt),
      .hold_nxt_i   (hold_nxt),
      .pwm_o        (pwm_o),
      .frame_start_o(frame_start_o)
   );
endmodule

// File: rtl/dpwm_modulator_chk.sv
module dpwm_modulator_chk #(
   parameter int unsigned SAMPLE_W    = 4,
   parameter int unsigned GUARD_SLOTS = 2
) (
   input logic clk_i,
   input logic rst_ni,
   input logic pwm_o,
   input logic frame_start_o
);
   localparam int unsigned FRAME = dpwm_pkg::frame_slots(SAMPLE_W, GUARD_SLOTS);
   localparam int unsigned CW    = $clog2(FRAME);
   localparam logic [CW-1:0] LAST     = CW'(FRAME - 1);
   localparam logic [CW-1:0] DATA_END = CW'(32'd1 << SAMPLE_W);

   logic [CW-1:0] slot_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)             slot_q <= '0;
      else if (slot_q == LAST) slot_q <= '0;
      else                     slot_q <= slot_q + 1'b1;
   end

   // R1: start flag lines up with an independent frame count
   p_frame_period_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_start_o == (slot_q == '0));

   // R1: start flag never lasts two cycles
   p_single_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_start_o |=> !frame_start_o);

   // R3: the line rises only at a frame start
   p_rise_at_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pwm_o) |-> frame_start_o);

   // R4: a frame that opens low stays low on its next slot
   p_zero_frame_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frame_start_o && !pwm_o) |=> !pwm_o);

   // R5: guard slots are always low
   p_guard_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (slot_q >= DATA_END) |-> !pwm_o);
endmodule

bind dpwm_modulator dpwm_modulator_chk #(
   .SAMPLE_W   (SAMPLE_W),
   .GUARD_SLOTS(GUARD_SLOTS)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .pwm_o        (pwm_o),
   .frame_start_o(frame_start_o)
);

// File: tb/dpwm_modulator_bench.sv
`timescale 1ns/1ps
module dpwm_modulator_bench;
   localparam int M     = 4;
   localparam int G     = 2;
   localparam int FRAME = (1 << M) + G;
   localparam int NVEC  = 7;

   // stimulus table: value driven, slot at which the strobe is given
   localparam int VEC_VAL [NVEC] = '{9, 3, 15, 0, 7, 12, 1};
   localparam int VEC_SLOT[NVEC] = '{5, 0, 12, 16, 2, 8, 10};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         smp_valid = 1'b0;
   logic [M-1:0] smp_data = '0;
   logic         pwm;
   logic         fs;

   int total = 0;
   int bad   = 0;
   int exp_w = 0;

   always #10 clk = ~clk;

   dpwm_modulator #(.SAMPLE_W(M), .GUARD_SLOTS(G), .BYPASS_EDGE(1'b1)) u_dpwm_modulator (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .smp_valid_i  (smp_valid),
      .smp_data_i   (smp_data),
      .pwm_o        (pwm),
      .frame_start_o(fs)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, expv, $time);
      end
   endtask

   // Called at the falling edge of slot 0. Checks one frame against exp_w,
   // optionally giving strobes at s1 / s2, and returns at the next slot 0.
   task automatic run_frame(input int v1, input int s1, input int v2, input int s2,
                            input string tag);
      bit driven = 1'b0;
      int next_w = exp_w;
      for (int s = 0; s < FRAME; s++) begin
         string t;
         check(fs == (s == 0), "R1 frame_start", int'(fs), int'(s == 0));
         if (s >= (1 << M))  t = "R5 guard";
         else if (driven)    t = "R6 mid-frame word";
         else if (exp_w == 0) t = "R4 zero";
         else                t = tag;
         check(pwm == (s < exp_w), t, int'(pwm), int'(s < exp_w));
         smp_valid = 1'b0;
         if (s == s1) begin
            smp_valid = 1'b1; smp_data = M'(v1); next_w = v1; driven = 1'b1;
         end
         if (s == s2) begin
            smp_valid = 1'b1; smp_data = M'(v2); next_w = v2; driven = 1'b1;
         end
         @(negedge clk);
      end
      smp_valid = 1'b0;
      exp_w = next_w;
   endtask

   initial begin
      #(20 * 200000);
      bad++; total++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R2: reset state
      check(pwm == 1'b0, "R2 reset pwm", int'(pwm), 0);
      check(fs == 1'b1, "R2 reset frame_start", int'(fs), 1);
      rst_n = 1'b1;
      exp_w = 0;
      run_frame(0, -1, 0, -1, "R2 first frame");

      // table walk: R3 widths, R6 mid-frame words, R4 zero, R5 guard
      for (int i = 0; i < NVEC; i++) begin
         run_frame(VEC_VAL[i], VEC_SLOT[i], 0, -1, "R3 width");
      end
      run_frame(0, -1, 0, -1, "R3 width");

      // R9: strobe on the final slot applies to the very next frame
      run_frame(6, FRAME - 1, 0, -1, "R3 width");
      run_frame(0, -1, 0, -1, "R9 boundary word");
      // R8: no word accepted, width repeats
      run_frame(0, -1, 0, -1, "R8 repeat");
      // R7: two words in one frame, the later one wins
      run_frame(2, 3, 11, FRAME - 2, "R8 repeat");
      run_frame(0, -1, 0, -1, "R7 last wins");
      // R3 boundary: maximum value leaves only one low data slot
      run_frame(15, 7, 0, -1, "R3 width");
      run_frame(0, -1, 0, -1, "R3 max width");

      // R2: reset in mid-frame, after a word was left pending
      run_frame(8, 4, 0, -1, "R3 width");
      repeat (5) @(negedge clk);
      smp_valid = 1'b1; smp_data = M'(13);
      @(negedge clk);
      smp_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check(pwm == 1'b0, "R2 reset pwm", int'(pwm), 0);
      check(fs == 1'b1, "R2 reset frame_start", int'(fs), 1);
      @(negedge clk);
      rst_n = 1'b1;
      exp_w = 0;
      run_frame(0, -1, 0, -1, "R2 cleared after reset");
      run_frame(0, -1, 0, -1, "R2 cleared after reset");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule